// File: doc/BRIEF.md
# Host Memory Access Port

This block is a slave port that lets an outside host fill and inspect a processor's on-chip program and data memories while the processor runs. The host drives a 16-bit multiplexed address/data bus and four strobes: select, address-latch, read and write. These strobes are asynchronous to the processor clock, so each one passes through a two-flop synchronizer before an edge detector turns it into a single internal event.

A latch cycle sends one control word on the bus. A flag bit in that word decides whether it carries a start address or an overlay page choice. After the address is loaded, the host streams reads or writes, and the port increments the address by itself after each completed word. A program word is 24 bits wide and moves as two host transfers. An acknowledge output drops while a transfer is being synchronized and carried out. When the block is strapped for host boot, a run-hold output keeps the processor core stopped until program location 0 has been written.

Top module: `hmdp_port`

## Requirements
- R1: While reset is asserted and just after it, `h_ack` is high, `run_hold` equals `boot_host`, both page outputs are zero and neither memory request is active.
- R2: A latch cycle is a word with bit 15 = 0. It loads the 14-bit start address from bits 13:0. Bit 14 selects the target, where 0 is program memory and 1 is data memory. The word takes effect when the synchronized latch strobe falls while select is held.
- R3: A latch word with bit 15 = 1 and bits 14:8 all zero sets the program page from bits 3:0 and the data page from bits 7:4. If any of bits 14:8 is nonzero, the word is ignored: the pages, the address and the target all stay the same.
- R4: Each data-memory read or write strobe makes exactly one 16-bit memory access at the current address. The address then increments by one, and it wraps from 0x3FFF to 0x0000.
- R5: A program word moves in two transfers. The first write carries bits 23:8, and the second write carries bits 7:0 on bus bits 7:0 and issues one 24-bit write. The first read returns bits 23:8, and the second read returns {8'h00, bits 7:0} with no further memory access. The address increments only after the second transfer.
- R6: `h_ack` is low from the cycle after the synchronized strobe edge until the access completes, and it is low whenever a memory request is active. It is high again six clock cycles after the raw strobe rises.
- R7: With `boot_host` high, `run_hold` stays high until the second transfer of a program write to address 0 completes. It then stays low. Program writes to other addresses do not release it.
- R8: A strobe held high for any length of time produces exactly one access.
- R9: Any address latch restarts the two-part program sequence at its first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_host | input | 1 | Strap: host-boot mode, static while running |
| h_sel | input | 1 | Host port select, active high, asynchronous |
| h_latch | input | 1 | Host address-latch strobe, active high |
| h_rd | input | 1 | Host read strobe, active high |
| h_wr | input | 1 | Host write strobe, active high |
| h_bus_i | input | 16 | Host bus, inbound |
| h_bus_o | output | 16 | Host bus, outbound read data |
| h_bus_oe | output | 1 | Drive enable for the outbound bus |
| h_ack | output | 1 | Port ready for a new strobe |
| run_hold | output | 1 | Holds the core stopped during host boot |
| pm_req | output | 1 | Program memory request |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 14 | Program memory address |
| pm_wdata | output | 24 | Program memory write data |
| pm_rdata | input | 24 | Program memory read data, valid the cycle after a request |
| dm_req | output | 1 | Data memory request |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 14 | Data memory address |
| dm_wdata | output | 16 | Data memory write data |
| dm_rdata | input | 16 | Data memory read data, valid the cycle after a request |
| pm_page | output | 4 | Program overlay page |
| dm_page | output | 4 | Data overlay page |

## Verification
The hardest state to reach from the ports is a half-finished program word that is interrupted by another event. One case is a latch arriving between the two transfers. Another is an overlay word arriving there, either valid or rejected. The random stimulus mixes latch, overlay, read and write operations on both memories and often lands between the halves. A shadow pointer and phase in the bench predict every returned word. Directed cases cover the address wrap at the top of the space, a strobe held for thirty cycles, and the boot release only on location 0.

// File: rtl/hmdp_pkg.sv
package hmdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_CAP  = 2'd2
  } hmdp_state_e;
endpackage

// File: rtl/hmdp_sync.sv
module hmdp_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hmdp_ctrl.sv
module hmdp_ctrl
  import hmdp_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 14,
  parameter int PM_W   = 24,
  parameter int DM_W   = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_host,
  input  logic              sel_s,
  input  logic              lat_s,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [BUS_W-1:0]  rd_word_o,
  output logic              ack_o,
  output logic              run_hold_o,
  output logic              pm_req_o,
  output logic              pm_we_o,
  output logic [ADDR_W-1:0] pm_addr_o,
  output logic [PM_W-1:0]   pm_wdata_o,
  input  logic [PM_W-1:0]   pm_rdata_i,
  output logic              dm_req_o,
  output logic              dm_we_o,
  output logic [ADDR_W-1:0] dm_addr_o,
  output logic [DM_W-1:0]   dm_wdata_o,
  input  logic [DM_W-1:0]   dm_rdata_i,
  output logic [PAGE_W-1:0] pm_page_o,
  output logic [PAGE_W-1:0] dm_page_o
);
  localparam int LO_W    = PM_W - BUS_W;
  localparam int FLAG_B  = BUS_W - 1;
  localparam int DEST_B  = BUS_W - 2;
  localparam int ZERO_LO = 2 * PAGE_W;

  hmdp_state_e       state_q, state_d;
  logic              lat_q, rd_q, wr_q;
  logic [BUS_W-1:0]  lat_word_q;
  logic [BUS_W-1:0]  wdata_q, wdata_d;
  logic              is_wr_q, is_wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              to_dm_q, to_dm_d;
  logic              ph_q, ph_d;
  logic [BUS_W-1:0]  hi_q, hi_d;
  logic [LO_W-1:0]   lo_q, lo_d;
  logic [BUS_W-1:0]  rdw_q, rdw_d;
  logic              booted_q, booted_d;
  logic [PAGE_W-1:0] pmpg_q, pmpg_d, dmpg_q, dmpg_d;
  logic              lat_ev, rd_ev, wr_ev, pm_need;

  assign lat_ev  = sel_s & lat_q & ~lat_s;
  assign rd_ev   = sel_s & rd_s & ~rd_q;
  assign wr_ev   = sel_s & wr_s & ~wr_q;
  assign pm_need = is_wr_q ? ph_q : ~ph_q;

  always_comb begin
    state_d  = state_q;
    wdata_d  = wdata_q;
    is_wr_d  = is_wr_q;
    addr_d   = addr_q;
    to_dm_d  = to_dm_q;
    ph_d     = ph_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    rdw_d    = rdw_q;
    booted_d = booted_q;
    pmpg_d   = pmpg_q;
    dmpg_d   = dmpg_q;
    case (state_q)
      ST_IDLE: begin
        if (lat_ev) begin
          if (!lat_word_q[FLAG_B]) begin
            addr_d  = lat_word_q[ADDR_W-1:0];
            to_dm_d = lat_word_q[DEST_B];
            ph_d    = 1'b0;
          end else if (lat_word_q[DEST_B:ZERO_LO] == '0) begin
            pmpg_d = lat_word_q[PAGE_W-1:0];
            dmpg_d = lat_word_q[ZERO_LO-1:PAGE_W];
          end
        end else if (wr_ev || rd_ev) begin
          is_wr_d = wr_ev;
          wdata_d = bus_i;
          state_d = ST_MEM;
        end
      end
      ST_MEM: state_d = ST_CAP;
      default: begin
        state_d = ST_IDLE;
        if (to_dm_q) begin
          if (!is_wr_q) rdw_d = dm_rdata_i;
          addr_d = addr_q + 1'b1;
        end else if (is_wr_q) begin
          if (!ph_q) begin
            hi_d = wdata_q;
            ph_d = 1'b1;
          end else begin
            ph_d   = 1'b0;
            addr_d = addr_q + 1'b1;
            if (addr_q == '0) booted_d = 1'b1;
          end
        end else begin
          if (!ph_q) begin
            rdw_d = pm_rdata_i[PM_W-1:LO_W];
            lo_d  = pm_rdata_i[LO_W-1:0];
            ph_d  = 1'b1;
          end else begin
            rdw_d  = {{(BUS_W-LO_W){1'b0}}, lo_q};
            ph_d   = 1'b0;
            addr_d = addr_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lat_q      <= 1'b0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      lat_word_q <= '0;
      wdata_q    <= '0;
      is_wr_q    <= 1'b0;
      addr_q     <= '0;
      to_dm_q    <= 1'b0;
      ph_q       <= 1'b0;
      hi_q       <= '0;
      lo_q       <= '0;
      rdw_q      <= '0;
      booted_q   <= 1'b0;
      pmpg_q     <= '0;
      dmpg_q     <= '0;
    end else begin
      state_q <= state_d;
      lat_q   <= lat_s;
      rd_q    <= rd_s;
      wr_q    <= wr_s;
      if (sel_s && lat_s) lat_word_q <= bus_i;
      wdata_q  <= wdata_d;
      is_wr_q  <= is_wr_d;
      addr_q   <= addr_d;
      to_dm_q  <= to_dm_d;
      ph_q     <= ph_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
      rdw_q    <= rdw_d;
      booted_q <= booted_d;
      pmpg_q   <= pmpg_d;
      dmpg_q   <= dmpg_d;
    end
  end

  assign ack_o      = (state_q == ST_IDLE);
  assign run_hold_o = boot_host & ~booted_q;
  assign rd_word_o  = rdw_q;
  assign pm_req_o   = (state_q == ST_MEM) & ~to_dm_q & pm_need;
  assign pm_we_o    = is_wr_q;
  assign pm_addr_o  = addr_q;
  assign pm_wdata_o = {hi_q, wdata_q[LO_W-1:0]};
  assign dm_req_o   = (state_q == ST_MEM) & to_dm_q;
  assign dm_we_o    = is_wr_q;
  assign dm_addr_o  = addr_q;
  assign dm_wdata_o = wdata_q[DM_W-1:0];
  assign pm_page_o  = pmpg_q;
  assign dm_page_o  = dmpg_q;

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_req_o && dm_req_o));
  // R6
  req_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req_o || dm_req_o) |-> !ack_o);
  // R7
  boot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_hold_o) |-> $past(pm_req_o && pm_we_o && (pm_addr_o == '0), 2));
  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |=> ($stable(pm_page_o) && $stable(dm_page_o)));
endmodule

// File: rtl/hmdp_port.sv
module hmdp_port #(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 14,
  parameter int PM_W   = 24,
  parameter int DM_W   = 16,
  parameter int PAGE_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_host,
  input  logic              h_sel,
  input  logic              h_latch,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [BUS_W-1:0]  h_bus_i,
  output logic [BUS_W-1:0]  h_bus_o,
  output logic              h_bus_oe,
  output logic              h_ack,
  output logic              run_hold,
  output logic              pm_req,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [PM_W-1:0]   pm_wdata,
  input  logic [PM_W-1:0]   pm_rdata,
  output logic              dm_req,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [DM_W-1:0]   dm_wdata,
  input  logic [DM_W-1:0]   dm_rdata,
  output logic [PAGE_W-1:0] pm_page,
  output logic [PAGE_W-1:0] dm_page
);
  localparam int NSTB = 4;

  logic [1:0]      rst_pipe;
  logic            rst_core_n;
  logic [NSTB-1:0] stb_raw, stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign stb_raw = {h_wr, h_rd, h_latch, h_sel};

  hmdp_sync #(.STAGES(SYNC_N), .W(NSTB)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (stb_raw),
    .q     (stb_s)
  );

  hmdp_ctrl #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .PM_W(PM_W), .DM_W(DM_W), .PAGE_W(PAGE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .boot_host  (boot_host),
    .sel_s      (stb_s[0]),
    .lat_s      (stb_s[1]),
    .rd_s       (stb_s[2]),
    .wr_s       (stb_s[3]),
    .bus_i      (h_bus_i),
    .rd_word_o  (h_bus_o),
    .ack_o      (h_ack),
    .run_hold_o (run_hold),
    .pm_req_o   (pm_req),
    .pm_we_o    (pm_we),
    .pm_addr_o  (pm_addr),
    .pm_wdata_o (pm_wdata),
    .pm_rdata_i (pm_rdata),
    .dm_req_o   (dm_req),
    .dm_we_o    (dm_we),
    .dm_addr_o  (dm_addr),
    .dm_wdata_o (dm_wdata),
    .dm_rdata_i (dm_rdata),
    .pm_page_o  (pm_page),
    .dm_page_o  (dm_page)
  );

  assign h_bus_oe = h_sel & h_rd;
endmodule

// File: tb/hmdp_port_bench.sv
module hmdp_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_host = 1'b1;
  logic h_sel = 1'b0, h_latch = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
  logic [15:0] h_bus_i = '0;
  logic [15:0] h_bus_o;
  logic h_bus_oe, h_ack, run_hold;
  logic pm_req, pm_we, dm_req, dm_we;
  logic [13:0] pm_addr, dm_addr;
  logic [23:0] pm_wdata, pm_rdata;
  logic [15:0] dm_wdata, dm_rdata;
  logic [3:0] pm_page, dm_page;

  always #2.5 clk = ~clk;

  hmdp_port u_hmdp_port (
    .clk(clk), .rst_n(rst_n), .boot_host(boot_host),
    .h_sel(h_sel), .h_latch(h_latch), .h_rd(h_rd), .h_wr(h_wr),
    .h_bus_i(h_bus_i), .h_bus_o(h_bus_o), .h_bus_oe(h_bus_oe),
    .h_ack(h_ack), .run_hold(run_hold),
    .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
    .pm_page(pm_page), .dm_page(dm_page)
  );

  function automatic logic [23:0] pm_init(int i);
    return {i[7:0] ^ 8'h5A, i[7:0], ~i[7:0]};
  endfunction
  function automatic logic [15:0] dm_init(int i);
    return {~i[7:0], i[7:0] ^ 8'hC3};
  endfunction

  // behavioural memories, 256 words each, indexed by the low address byte
  logic [23:0] mem_pm [256];
  logic [15:0] mem_dm [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        mem_pm[i] <= pm_init(i);
        mem_dm[i] <= dm_init(i);
      end
    end else begin
      if (pm_req) begin
        if (pm_we) mem_pm[pm_addr[7:0]] <= pm_wdata;
        pm_rdata <= mem_pm[pm_addr[7:0]];
      end
      if (dm_req) begin
        if (dm_we) mem_dm[dm_addr[7:0]] <= dm_wdata;
        dm_rdata <= mem_dm[dm_addr[7:0]];
      end
    end
  end

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // shadow model
  logic [23:0] sh_pm [256];
  logic [15:0] sh_dm [256];
  logic [13:0] e_addr = '0;
  bit e_dm = 0, e_ph = 0, e_booted = 0;
  logic [15:0] e_hi = '0;
  logic [7:0] e_lo = '0;
  logic [3:0] e_pmpg = '0, e_dmpg = '0;

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic access(bit wr, logic [15:0] d, int hold, output logic [15:0] q);
    @(negedge clk);
    h_bus_i = d; h_sel = 1'b1;
    if (wr) h_wr = 1'b1; else h_rd = 1'b1;
    repeat (3) @(negedge clk);
    chk(h_ack == 1'b0, "R6 ack low mid-access", h_ack, 0);
    repeat (3) @(negedge clk);
    chk(h_ack == 1'b1, "R6 ack back high", h_ack, 1);
    repeat (hold) @(negedge clk);
    q = h_bus_o;
    h_wr = 1'b0; h_rd = 1'b0;
    @(negedge clk);
    h_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic latch_word(logic [15:0] d);
    @(negedge clk);
    h_bus_i = d; h_sel = 1'b1; h_latch = 1'b1;
    repeat (4) @(negedge clk);
    h_latch = 1'b0;
    repeat (5) @(negedge clk);
    h_sel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_addr(bit dm, logic [13:0] a);
    latch_word({1'b0, dm, a});
    e_addr = a; e_dm = dm; e_ph = 0;
  endtask

  task automatic set_pages(logic [3:0] pp, logic [3:0] dp, logic [6:0] junk);
    latch_word({1'b1, junk, dp, pp});
    if (junk == 0) begin e_pmpg = pp; e_dmpg = dp; end
    chk(pm_page == e_pmpg, "R3 program page", pm_page, e_pmpg);
    chk(dm_page == e_dmpg, "R3 data page", dm_page, e_dmpg);
  endtask

  task automatic host_wr(logic [15:0] d, int hold);
    logic [15:0] q;
    access(1'b1, d, hold, q);
    if (e_dm) begin
      sh_dm[e_addr[7:0]] = d; e_addr++;
    end else if (!e_ph) begin
      e_hi = d; e_ph = 1;
    end else begin
      sh_pm[e_addr[7:0]] = {e_hi, d[7:0]};
      if (e_addr == 0) e_booted = 1;
      e_addr++; e_ph = 0;
    end
  endtask

  task automatic host_rd(string req, int hold);
    logic [15:0] q, e;
    access(1'b0, 16'h0, hold, q);
    if (e_dm) begin
      e = sh_dm[e_addr[7:0]]; e_addr++;
    end else if (!e_ph) begin
      e = sh_pm[e_addr[7:0]][23:8]; e_lo = sh_pm[e_addr[7:0]][7:0]; e_ph = 1;
    end else begin
      e = {8'h00, e_lo}; e_ph = 0; e_addr++;
    end
    chk(q == e, req, q, e);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1DEA5));
    for (int i = 0; i < 256; i++) begin
      sh_pm[i] = pm_init(i);
      sh_dm[i] = dm_init(i);
    end
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(h_ack == 1'b1, "R1 ack in reset", h_ack, 1);
    chk(run_hold == 1'b1, "R1 hold in reset", run_hold, 1);
    chk({pm_page, dm_page} == 8'h0, "R1 pages", {pm_page, dm_page}, 0);
    chk({pm_req, dm_req} == 2'b0, "R1 requests", {pm_req, dm_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(h_ack == 1'b1 && run_hold == 1'b1, "R1 after release", {h_ack, run_hold}, 3);

    // R2 R4 data stream
    set_addr(1'b1, 14'h0010);
    host_wr(16'hA001, 0); host_wr(16'hB002, 0); host_wr(16'hC003, 0);
    set_addr(1'b1, 14'h0010);
    host_rd("R2 R4 data read 0", 0); host_rd("R4 data read 1", 0); host_rd("R4 data read 2", 0);

    // R7 boot hold
    set_addr(1'b0, 14'h0005);
    host_wr(16'h1234, 0); host_wr(16'h0056, 0);
    chk(run_hold == 1'b1, "R7 hold after other address", run_hold, 1);
    set_addr(1'b0, 14'h0000);
    host_wr(16'hBEEF, 0);
    chk(run_hold == 1'b1, "R7 hold after first half", run_hold, 1);
    host_wr(16'hFF77, 0);
    chk(run_hold == 1'b0, "R7 released", run_hold, 0);

    // R5 two-part program read
    set_addr(1'b0, 14'h0000);
    host_rd("R5 pm upper", 0); host_rd("R5 pm lower", 0);
    host_rd("R5 pm next upper", 0);
    // R9 latch restarts phase
    set_addr(1'b0, 14'h0005);
    host_rd("R9 upper", 0);
    set_addr(1'b0, 14'h0005);
    host_rd("R9 upper again", 0); host_rd("R9 lower", 0);

    // R4 wrap
    set_addr(1'b1, 14'h3FFF);
    host_wr(16'h7E7E, 0); host_wr(16'h8181, 0);
    set_addr(1'b1, 14'h3FFF);
    host_rd("R4 wrap top", 0); host_rd("R4 wrap zero", 0);

    // R8 long strobe yields one access
    set_addr(1'b1, 14'h0040);
    host_wr(16'h4444, 30);
    host_rd("R8 one access per long write", 30);
    host_rd("R8 next address", 0);

    // R3 overlay, valid and rejected, address untouched
    set_addr(1'b1, 14'h0020);
    set_pages(4'h5, 4'h7, 7'h00);
    set_pages(4'h2, 4'h3, 7'h11);
    host_rd("R3 address kept after overlay", 0);

    // random mix
    for (int k = 0; k < 150; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) set_addr($urandom_range(0, 1), 14'($urandom_range(0, 16383)));
      else if (op == 1) set_pages(4'($urandom), 4'($urandom), ($urandom_range(0, 1) == 0) ? 7'h0 : 7'($urandom_range(1, 127)));
      else if (op < 6) host_wr(16'($urandom), 0);
      else host_rd("R4 R5 random read", 0);
    end

    chk(run_hold == !e_booted, "R7 final hold", run_hold, !e_booted);
    for (int i = 0; i < 256; i++) begin
      chk(mem_dm[i] == sh_dm[i], "R4 data memory content", mem_dm[i], sh_dm[i]);
      chk(mem_pm[i] == sh_pm[i], "R5 program memory content", mem_pm[i], sh_pm[i]);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule